// File: doc/BRIEF.md
# Packetized Isochronous Byte-Stream Port

This block joins an external byte-wide stream, a source or a sink of isochronous data, to a packet FIFO that a link layer fills or drains one whole packet at a time. A direction input chooses the mode. With the direction low the external side writes bytes into the FIFO, and the link side takes them out as fixed-length packets. With the direction high the link side delivers packets of any length, each with a CRC-error flag, and the external side reads them out byte by byte.

An access-enable output paces the external side in whole packets. In receive mode it is raised only while a fully received packet is held, and it drops for one cycle after each packet has been read. In transmit mode it is lowered when the store is full. After a bus reset it is lowered at the next packet boundary and stays low until one packet has gone out to the link. A direction change that arrives while a packet is part-way out to the link waits for that packet to end. A clear control empties the store, but only when one of two enabling mode bits is set.

The whole block runs on the external byte clock. The link side uses the same clock and a byte-wide valid/ready interface with a last marker.

Top module: `iso_byte_port`

## Requirements
- R1: After reset the block is in receive mode. Access-enable is low, the data bus is released (data_oe_o = 0), the CRC flag is low, tx_valid_o is low and rx_ready_o is high.
- R2: A 1-to-0 change of dir_i empties the store, including any complete received packets. The block then enters transmit mode with access-enable high.
- R3: In transmit mode a byte on data_i is stored at the rising edge when dv_i and access-enable are both high. tx_valid_o rises only once cfg_len_i bytes are stored. The link receives the bytes in their original order, with tx_last_o on the cfg_len_i-th byte of each packet. tx_valid_o and tx_data_o stay unchanged while tx_ready_i is low.
- R4: In transmit mode access-enable goes low when the store holds DEPTH bytes, and a byte offered while the store is full is discarded.
- R5: With cfg_nofull_i high, access-enable stays high while the store is full, and offered bytes are still discarded.
- R6: A pulse on bus_reset_i in transmit mode lets writes continue up to the next packet boundary. Access-enable then stays low, and bytes offered meanwhile are discarded, until one packet has completed on the link side.
- R7: In receive mode access-enable is high only while at least one packet whose last byte has arrived is held.
- R8: In receive mode data_oe_o is high exactly when dv_i and access-enable are both high. Bytes then appear on data_o in arrival order, one per clock, with bit 7 as MSB. Otherwise data_oe_o is low.
- R9: After the last byte of a packet is read, access-enable is low for exactly one cycle. It then returns high if another complete packet is held.
- R10: crc_err_o is high while bytes of a packet whose rx_crc_err_i was set on its last byte are being driven, and low for other packets.
- R11: A 0-to-1 change of dir_i while a packet is part-way out on the link lets that packet finish. During that wait access-enable and rx_ready_o are low. The block then empties the store and enters receive mode.
- R12: A pulse on clr_i with cfg_point_i or cfg_lenchk_i set empties the store and holds access-enable and rx_ready_o low for CLR_HOLD cycles. With both bits clear, clr_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External byte clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | 1 = receive (store to port), 0 = transmit (port to store) |
| dv_i | input | 1 | Data-valid from the external side |
| data_i | input | 8 | Byte written by the external side |
| data_o | output | 8 | Byte read by the external side |
| data_oe_o | output | 1 | Drive enable for data_o; low means high-impedance |
| acc_en_o | output | 1 | Access-enable to the external side |
| crc_err_o | output | 1 | Current byte belongs to a packet with a CRC error |
| bus_reset_i | input | 1 | Bus-reset event pulse |
| cfg_len_i | input | LEN_W | Transmit packet length in bytes (1..DEPTH) |
| cfg_nofull_i | input | 1 | Keep access-enable high when full in transmit mode |
| cfg_point_i | input | 1 | Mode bit that enables the clear control |
| cfg_lenchk_i | input | 1 | Mode bit that enables the clear control |
| clr_i | input | 1 | Store clear request pulse |
| tx_valid_o | output | 1 | Packet byte offered to the link |
| tx_ready_i | input | 1 | Link accepts the offered byte |
| tx_data_o | output | 8 | Byte offered to the link |
| tx_last_o | output | 1 | Offered byte ends its packet |
| rx_valid_i | input | 1 | Link offers a received byte |
| rx_ready_o | output | 1 | Block accepts a received byte |
| rx_data_i | input | 8 | Received byte from the link |
| rx_last_i | input | 1 | Received byte ends its packet |
| rx_crc_err_i | input | 1 | CRC error flag, taken with the last byte |

## Verification
A wrong complete-packet count shows up at access-enable in the same cycle. The port may open in receive mode before a packet has fully arrived, or the link may be offered a short packet. A slipped read or write pointer shows up as the wrong byte on data_o or tx_data_o at the next handshake. A lost boundary count shows up as tx_last_o on the wrong beat within one packet length. A direction or bus-reset state that is not restored shows up as access-enable or rx_ready_o held at the wrong level at once. The bench checks these outputs cycle by cycle around each such event.

// File: rtl/isoport_pkg.sv
package isoport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_RX    = 2'd0,
        MODE_TX    = 2'd1,
        MODE_DRAIN = 2'd2
    } port_mode_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } fifo_ent_t;

    function automatic logic clear_enabled(input logic point_bit, input logic lenchk_bit);
        return point_bit | lenchk_bit;
    endfunction

endpackage

// File: rtl/isoport_fifo.sv
module isoport_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/isoport_ctrl.sv
module isoport_ctrl
    import isoport_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int LEN_W    = 11,
    parameter int CLR_HOLD = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dir_i,
    input  logic                        dv_i,
    input  logic                        bus_reset_i,
    input  logic [LEN_W-1:0]            cfg_len_i,
    input  logic                        cfg_nofull_i,
    input  logic                        cfg_point_i,
    input  logic                        cfg_lenchk_i,
    input  logic                        clr_i,
    input  logic                        tx_ready_i,
    input  logic                        rx_valid_i,
    input  logic                        rx_last_i,
    input  logic                        byte_full,
    input  logic                        flag_full,
    input  logic                        head_last,
    output port_mode_e                  mode_o,
    output logic                        fifo_clr_o,
    output logic                        clr_req_o,
    output logic                        acc_en_o,
    output logic                        port_push_o,
    output logic                        port_last_o,
    output logic                        port_pop_o,
    output logic                        tx_valid_o,
    output logic                        link_pop_o,
    output logic                        rx_ready_o,
    output logic                        link_push_o,
    output logic [$clog2(DEPTH+1)-1:0]  pkt_cnt_o
);
    localparam int PCW = $clog2(DEPTH+1);
    localparam int HW  = $clog2(CLR_HOLD+1);

    port_mode_e     mode_q, mode_d;
    logic           dir_q, dir_fall, dir_rise, dir_clr;
    logic [PCW-1:0] pkt_q, pkt_d;
    logic [LEN_W-1:0] wcnt_q, wcnt_d;
    logic           arm_q, stop_q, busy_q, gap_q;
    logic [HW-1:0]  hold_q;
    logic           is_tx, is_rx, quiet, clr_all;
    logic           pkt_end_tx, pkt_end_port, pkt_in;

    assign is_tx    = (mode_q == MODE_TX);
    assign is_rx    = (mode_q == MODE_RX);
    assign quiet    = (hold_q == '0);
    assign dir_fall = dir_q & ~dir_i;
    assign dir_rise = ~dir_q & dir_i;

    assign clr_req_o = clr_i & clear_enabled(cfg_point_i, cfg_lenchk_i);

    // external side
    assign acc_en_o = is_tx ? (quiet && !stop_q && (cfg_nofull_i || !byte_full))
                            : (is_rx && quiet && (pkt_q != '0) && !gap_q);
    assign port_push_o = is_tx && dv_i && acc_en_o && !byte_full;
    assign port_last_o = (wcnt_q == cfg_len_i - 1'b1);
    assign port_pop_o  = is_rx && dv_i && acc_en_o;

    // link side
    assign tx_valid_o  = (is_tx && (busy_q || (pkt_q != '0)))
                       || ((mode_q == MODE_DRAIN) && busy_q);
    assign link_pop_o  = tx_valid_o && tx_ready_i;
    assign rx_ready_o  = is_rx && quiet && !byte_full && !flag_full;
    assign link_push_o = rx_valid_i && rx_ready_o;

    assign pkt_end_tx   = link_pop_o && head_last;
    assign pkt_end_port = port_pop_o && head_last;
    assign pkt_in       = (port_push_o && port_last_o) || (link_push_o && rx_last_i);

    always_comb begin
        mode_d  = mode_q;
        dir_clr = 1'b0;
        if (dir_fall) begin
            mode_d  = MODE_TX;
            dir_clr = 1'b1;
        end else if (dir_rise && (mode_q == MODE_TX)) begin
            if (busy_q && !pkt_end_tx) begin
                mode_d = MODE_DRAIN;
            end else begin
                mode_d  = MODE_RX;
                dir_clr = 1'b1;
            end
        end else if ((mode_q == MODE_DRAIN) && (!busy_q || pkt_end_tx)) begin
            mode_d  = MODE_RX;
            dir_clr = 1'b1;
        end
    end

    assign clr_all    = dir_clr | clr_req_o;
    assign fifo_clr_o = clr_all;

    always_comb begin
        pkt_d = pkt_q + PCW'(pkt_in) - PCW'(pkt_end_tx | pkt_end_port);
        wcnt_d = wcnt_q;
        if (port_push_o) wcnt_d = port_last_o ? '0 : wcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RX;
            dir_q  <= 1'b1;
            pkt_q  <= '0;
            wcnt_q <= '0;
            arm_q  <= 1'b0;
            stop_q <= 1'b0;
            busy_q <= 1'b0;
            gap_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            mode_q <= mode_d;
            dir_q  <= dir_i;
            if (clr_req_o)   hold_q <= HW'(CLR_HOLD);
            else if (!quiet) hold_q <= hold_q - 1'b1;
            if (clr_all) begin
                pkt_q  <= '0;
                wcnt_q <= '0;
                arm_q  <= 1'b0;
                stop_q <= 1'b0;
                busy_q <= 1'b0;
                gap_q  <= 1'b0;
            end else begin
                pkt_q  <= pkt_d;
                wcnt_q <= wcnt_d;
                gap_q  <= pkt_end_port;
                if (link_pop_o) busy_q <= !head_last;
                if (stop_q && (pkt_end_tx || (pkt_q == '0))) begin
                    stop_q <= 1'b0;
                end else if ((arm_q || (is_tx && bus_reset_i)) && (wcnt_d == '0)) begin
                    stop_q <= 1'b1;
                    arm_q  <= 1'b0;
                end else if (is_tx && bus_reset_i) begin
                    arm_q <= 1'b1;
                end
            end
        end
    end

    assign mode_o    = mode_q;
    assign pkt_cnt_o = pkt_q;

endmodule

// File: rtl/iso_byte_port.sv
module iso_byte_port
    import isoport_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter int LEN_W     = 11,
    parameter int PKT_SLOTS = 16,
    parameter int CLR_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_i,
    input  logic              dv_i,
    input  logic [7:0]        data_i,
    output logic [7:0]        data_o,
    output logic              data_oe_o,
    output logic              acc_en_o,
    output logic              crc_err_o,
    input  logic              bus_reset_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_nofull_i,
    input  logic              cfg_point_i,
    input  logic              cfg_lenchk_i,
    input  logic              clr_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_last_i,
    input  logic              rx_crc_err_i
);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int FCW = $clog2(PKT_SLOTS+1);
    localparam int EW  = $bits(fifo_ent_t);

    port_mode_e      mode;
    fifo_ent_t       head, wr_ent;
    logic [CW-1:0]   byte_cnt;
    logic [CW-1:0]   pkt_cnt;
    logic [FCW-1:0]  flag_cnt;
    logic            flag_head;
    logic            fifo_clr, clr_req;
    logic            port_push, port_last, port_pop, link_pop, link_push;
    logic            byte_full, flag_full;

    assign byte_full = (byte_cnt == CW'(DEPTH));
    assign flag_full = (flag_cnt == FCW'(PKT_SLOTS));

    assign wr_ent = port_push ? '{last: port_last, data: data_i}
                              : '{last: rx_last_i, data: rx_data_i};

    isoport_ctrl #(
        .DEPTH    (DEPTH),
        .LEN_W    (LEN_W),
        .CLR_HOLD (CLR_HOLD)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .dir_i        (dir_i),
        .dv_i         (dv_i),
        .bus_reset_i  (bus_reset_i),
        .cfg_len_i    (cfg_len_i),
        .cfg_nofull_i (cfg_nofull_i),
        .cfg_point_i  (cfg_point_i),
        .cfg_lenchk_i (cfg_lenchk_i),
        .clr_i        (clr_i),
        .tx_ready_i   (tx_ready_i),
        .rx_valid_i   (rx_valid_i),
        .rx_last_i    (rx_last_i),
        .byte_full    (byte_full),
        .flag_full    (flag_full),
        .head_last    (head.last),
        .mode_o       (mode),
        .fifo_clr_o   (fifo_clr),
        .clr_req_o    (clr_req),
        .acc_en_o     (acc_en_o),
        .port_push_o  (port_push),
        .port_last_o  (port_last),
        .port_pop_o   (port_pop),
        .tx_valid_o   (tx_valid_o),
        .link_pop_o   (link_pop),
        .rx_ready_o   (rx_ready_o),
        .link_push_o  (link_push),
        .pkt_cnt_o    (pkt_cnt)
    );

    isoport_fifo #(
        .W     (EW),
        .DEPTH (DEPTH)
    ) u_bytes (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (port_push | link_push),
        .wdata (wr_ent),
        .pop   (port_pop | link_pop),
        .rdata (head),
        .count (byte_cnt)
    );

    isoport_fifo #(
        .W     (1),
        .DEPTH (PKT_SLOTS)
    ) u_flags (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (link_push & rx_last_i),
        .wdata (rx_crc_err_i),
        .pop   (port_pop & head.last),
        .rdata (flag_head),
        .count (flag_cnt)
    );

    assign data_o    = head.data;
    assign data_oe_o = port_pop;
    assign crc_err_o = port_pop & flag_head;
    assign tx_data_o = head.data;
    assign tx_last_o = head.last;

endmodule

// File: rtl/isoport_chk.sv
module isoport_chk
    import isoport_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        acc_en_o,
    input logic                        data_oe_o,
    input logic                        crc_err_o,
    input logic                        tx_valid_o,
    input logic                        tx_ready_i,
    input logic [7:0]                  tx_data_o,
    input logic                        tx_last_o,
    input logic                        rx_ready_o,
    input logic                        clr_req,
    input logic                        fifo_clr,
    input logic [$clog2(DEPTH+1)-1:0]  byte_cnt,
    input logic [$clog2(DEPTH+1)-1:0]  pkt_cnt,
    input port_mode_e                  mode
);
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        byte_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && !fifo_clr) |=>
            (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    // R7
    rx_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en_o && mode == MODE_RX) |-> (pkt_cnt != '0));

    // R8
    drive_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (byte_cnt != '0));

    // R10
    crc_only_driven_chk: assert property (@(posedge clk) disable iff (rst)
        crc_err_o |-> data_oe_o);

    // R12
    clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (!acc_en_o && !rx_ready_o));

    // R11
    drain_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DRAIN) |-> (!acc_en_o && !rx_ready_o));

endmodule

bind iso_byte_port isoport_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_iso_byte_port.sv
module sim_iso_byte_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int LEN_W      = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_i = 1'b1, dv_i = 1'b0, bus_reset_i = 1'b0;
    logic [7:0] data_i = '0, data_o, tx_data_o, rx_data_i = '0;
    logic data_oe_o, acc_en_o, crc_err_o;
    logic [LEN_W-1:0] cfg_len_i = LEN_W'(4);
    logic cfg_nofull_i = 1'b0, cfg_point_i = 1'b0, cfg_lenchk_i = 1'b0, clr_i = 1'b0;
    logic tx_valid_o, tx_ready_i = 1'b0, tx_last_o;
    logic rx_valid_i = 1'b0, rx_ready_o, rx_last_i = 1'b0, rx_crc_err_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_byte_port #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u0 (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic sett();
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_pkt(input logic [7:0] base, input int n, input logic err);
        for (int i = 0; i < n; i++) begin
            rx_valid_i = 1'b1; rx_data_i = base + 8'(i);
            rx_last_i = (i == n-1); rx_crc_err_i = err;
            cyc();
        end
        rx_valid_i = 1'b0; rx_last_i = 1'b0; rx_crc_err_i = 1'b0;
    endtask

    task automatic t_reset();
        sett();
        chk("R1 acc_en", acc_en_o, 0);
        chk("R1 data_oe", data_oe_o, 0);
        chk("R1 crc_err", crc_err_o, 0);
        chk("R1 tx_valid", tx_valid_o, 0);
        chk("R1 rx_ready", rx_ready_o, 1);
    endtask

    task automatic t_rx();
        for (int i = 0; i < 4; i++) begin
            rx_valid_i = 1'b1; rx_data_i = 8'h10 + 8'(i); rx_last_i = (i == 3);
            if (i == 3) begin sett(); chk("R7 no access before last byte", acc_en_o, 0); end
            cyc();
        end
        rx_valid_i = 1'b0; rx_last_i = 1'b0;
        sett();
        chk("R7 access after complete packet", acc_en_o, 1);
        chk("R8 bus released while dv low", data_oe_o, 0);
        rx_pkt(8'hA0, 3, 1'b1);
        dv_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            sett();
            chk("R8 drive", data_oe_o, 1);
            chk("R8 byte order", data_o, 8'h10 + 8'(i));
            chk("R10 clean packet", crc_err_o, 0);
            cyc();
        end
        sett();
        chk("R9 gap after packet", acc_en_o, 0);
        chk("R8 released in gap", data_oe_o, 0);
        cyc();
        sett();
        chk("R9 reopen for next packet", acc_en_o, 1);
        for (int i = 0; i < 3; i++) begin
            sett();
            chk("R8 drive second", data_oe_o, 1);
            chk("R8 second byte order", data_o, 8'hA0 + 8'(i));
            chk("R10 error packet", crc_err_o, 1);
            cyc();
        end
        sett();
        chk("R7 closed when empty", acc_en_o, 0);
        chk("R8 released when empty", data_oe_o, 0);
        dv_i = 1'b0;
    endtask

    task automatic t_tx();
        rx_pkt(8'h40, 4, 1'b0);
        dir_i = 1'b0;
        cyc();
        sett();
        chk("R2 transmit mode open", acc_en_o, 1);
        chk("R2 received packet emptied", tx_valid_o, 0);
        for (int i = 0; i < 8; i++) begin
            dv_i = 1'b1; data_i = 8'h50 + 8'(i);
            cyc();
            if (i == 2) begin sett(); chk("R3 no link packet at 3 bytes", tx_valid_o, 0); end
            if (i == 3) begin
                sett();
                chk("R3 link packet at length", tx_valid_o, 1);
                chk("R3 first byte", tx_data_o, 8'h50);
            end
        end
        dv_i = 1'b0;
        tx_ready_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sett();
            chk("R3 link byte", tx_data_o, 8'h50 + 8'(i));
            chk("R3 last marker", tx_last_o, (i % 4) == 3);
            cyc();
        end
        sett();
        chk("R3 link idle after drain", tx_valid_o, 0);
        tx_ready_i = 1'b0;
    endtask

    task automatic t_full();
        int bad;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            dv_i = 1'b1; data_i = 8'(i);
            sett();
            if (!acc_en_o) bad++;
            cyc();
        end
        dv_i = 1'b0;
        chk("R4 open while space", bad, 0);
        sett();
        chk("R4 closed when full", acc_en_o, 0);
        dv_i = 1'b1; data_i = 8'hEE; cyc(); dv_i = 1'b0;
        cfg_nofull_i = 1'b1;
        sett();
        chk("R5 open at full with bit set", acc_en_o, 1);
        dv_i = 1'b1; data_i = 8'hDD; cyc(); dv_i = 1'b0;
        cfg_nofull_i = 1'b0;
        bad = 0;
        tx_ready_i = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            sett();
            if (!tx_valid_o || tx_data_o != 8'(i) || tx_last_o != ((i % 4) == 3)) bad++;
            cyc();
        end
        chk("R4 full contents intact", bad, 0);
        sett();
        chk("R5 bytes offered at full dropped", tx_valid_o, 0);
        tx_ready_i = 1'b0;
    endtask

    task automatic t_busreset();
        dv_i = 1'b1; data_i = 8'h61; cyc();
        data_i = 8'h62; cyc();
        dv_i = 1'b0; bus_reset_i = 1'b1; cyc();
        bus_reset_i = 1'b0;
        dv_i = 1'b1; data_i = 8'h63;
        sett(); chk("R6 open until boundary", acc_en_o, 1); cyc();
        data_i = 8'h64;
        sett(); chk("R6 open until boundary", acc_en_o, 1); cyc();
        sett();
        chk("R6 closed at boundary", acc_en_o, 0);
        data_i = 8'h65; cyc(); cyc();
        dv_i = 1'b0;
        tx_ready_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            sett();
            chk("R6 packet sent", tx_data_o, 8'h61 + 8'(i));
            cyc();
        end
        sett();
        chk("R6 reopen after one packet", acc_en_o, 1);
        chk("R6 byte during hold ignored", tx_valid_o, 0);
        tx_ready_i = 1'b0;
    endtask

    task automatic t_drain();
        for (int i = 0; i < 8; i++) begin
            dv_i = 1'b1; data_i = 8'h70 + 8'(i); cyc();
        end
        dv_i = 1'b0;
        tx_ready_i = 1'b1;
        cyc(); cyc();
        dir_i = 1'b1;
        sett();
        chk("R11 mid packet byte", tx_data_o, 8'h72);
        cyc();
        sett();
        chk("R11 port closed while draining", acc_en_o, 0);
        chk("R11 link rx closed while draining", rx_ready_o, 0);
        chk("R11 packet continues", tx_valid_o, 1);
        chk("R11 final byte", tx_data_o, 8'h73);
        chk("R11 final marker", tx_last_o, 1);
        cyc();
        tx_ready_i = 1'b0;
        sett();
        chk("R11 second packet dropped", tx_valid_o, 0);
        chk("R11 receive mode", rx_ready_o, 1);
    endtask

    task automatic t_clear();
        rx_pkt(8'h30, 4, 1'b0);
        sett();
        chk("R7 packet held", acc_en_o, 1);
        clr_i = 1'b1; cyc(); clr_i = 1'b0;
        sett();
        chk("R12 clear ignored without mode bit", acc_en_o, 1);
        cfg_lenchk_i = 1'b1; clr_i = 1'b1; cyc();
        clr_i = 1'b0; cfg_lenchk_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sett();
            chk("R12 hold rx_ready", rx_ready_o, 0);
            chk("R12 hold access", acc_en_o, 0);
            cyc();
        end
        sett();
        chk("R12 rx_ready back", rx_ready_o, 1);
        chk("R12 store emptied", acc_en_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        rst = 1'b0;
        t_reset();
        t_rx();
        t_tx();
        t_full();
        t_busreset();
        t_drain();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule